// File: doc/BRIEF.md
# Per-Line Transmit Queue Scheduler

This block sits between a host and a set of serial line transmitters. It keeps one character queue per line. The host picks a line with a select field and then writes characters into that line's queue. A line leaves its queue only while the host has enabled it. A round-robin arbiter moves the characters one at a time to a shared output, which uses a valid/ready handshake toward the transmitters.

When a line runs dry, or when the host discards its queue, the block records a completion for that line. Completions for several lines are kept together. They are shown one at a time through a status flag and a line-number field, and each one stays shown until the host acknowledges it. An external fetch-error input also posts a completion, and that completion carries an error flag. A transmit interrupt output follows the status flag, gated by an enable input.

Top module: `txSiloSched`

## Requirements
- R1: Each line's queue holds DEPTH (default 32) characters. A write to a line whose queue is full at that cycle is dropped and sets that line's sticky overflow flag. `ovfFlag` shows the flag for the selected line.
- R2: `fifoCount` reports how many characters are queued for the line on `selLine`, from 0 to DEPTH.
- R3: Characters of one line leave in the order they were written. `outLine` names the source line and `outData` carries the character.
- R4: With no character on hold, the line offered is the first eligible line found after the last accepted line, searching upward with wrap-around. A line is eligible when it is enabled, holds data and is not being flushed in that cycle. After reset the search starts at line 0.
- R5: A character offered with `outReady` low is offered again unchanged in the next cycle. This holds even if its line is disabled in the meantime. Only a flush of that line withdraws it.
- R6: When a line's enable is cleared, no new character from that line is offered, and its queue is kept. When the enable is set again, output resumes with the next unsent character.
- R7: A `flushReq` pulse empties the selected line's queue, so its count reads 0 from the next cycle, and posts a completion for that line. A write issued in the same cycle as the flush is dropped.
- R8: A completion is posted for a line when its last queued character is accepted and no write to that line happens in the same cycle.
- R9: `csrTi` is 1 while any completion is pending. `csrLine` then shows the lowest-numbered pending line.
- R10: An `ackWr` pulse clears the completion currently shown. If a new completion for that same line arrives in the same cycle, the new completion wins.
- R11: An `nxmIn` pulse posts a completion with an error for the line on `nxmLine`. `csrNxm` shows the error flag of the completion being shown, and the acknowledge clears it.
- R12: `txInt` equals `csrTi` when `tiEnable` is 1 and is 0 otherwise.
- R13: After reset, every queue is empty, every line is disabled, no completion is pending and `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selLine | input | LW | Line the host is addressing |
| wrChar | input | 1 | Write `wrData` into the selected line's queue |
| wrData | input | DATA_W | Character to enqueue |
| teWr | input | 1 | Load the selected line's enable from `teVal` |
| teVal | input | 1 | New enable value |
| flushReq | input | 1 | Discard the selected line's queue (single-cycle pulse) |
| ackWr | input | 1 | Acknowledge the completion being shown |
| tiEnable | input | 1 | Transmit interrupt enable |
| nxmIn | input | 1 | Fetch-error pulse |
| nxmLine | input | LW | Line that the fetch error belongs to |
| outReady | input | 1 | Transmitter accepts the offered character |
| outValid | output | 1 | A character is offered |
| outData | output | DATA_W | Offered character |
| outLine | output | LW | Line of the offered character |
| fifoCount | output | CW | Queue depth of the selected line |
| ovfFlag | output | 1 | Sticky overflow flag of the selected line |
| csrTi | output | 1 | Completion pending |
| csrLine | output | LW | Line of the completion being shown |
| csrNxm | output | 1 | The completion being shown carries an error |
| txInt | output | 1 | Transmit interrupt |

## Verification
Several directed patterns come first. Filling a disabled line past its capacity separates a dropped write from a stored one. Holding `outReady` low while the line is disabled shows whether an offered character stays stable or is taken back. A flush, a single-character drain and a fetch error each post a completion in a different way, so comparing the three shows whether the right line and the right error flag are presented. A long random phase follows. It mixes writes to all lines, enable changes, back-pressure, flushes, acknowledges and errors. A reference model compares every offer with its own round-robin choice and every character with its own per-line queue, so a wrong arbitration order, a reordered character or a missed completion all show up as a mismatch.

// File: rtl/txs_pkg.sv
`timescale 1ns/1ps
package txs_pkg;
  // strobes sent from the control to the datapath
  typedef struct packed {
    logic pushEn;   // write attempt on host line
    logic popEn;    // accepted handshake on granted line
    logic flushEn;  // discard host line
  } strobe_t;
endpackage

// File: rtl/txs_datapath.sv
`timescale 1ns/1ps
module txs_datapath #(
  parameter int NUM_LINES = 8,
  parameter int DEPTH     = 32,
  parameter int DATA_W    = 8,
  localparam int LW = $clog2(NUM_LINES),
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  txs_pkg::strobe_t                strb,
  input  logic [LW-1:0]                   hostLine,
  input  logic [DATA_W-1:0]               wrData,
  input  logic [LW-1:0]                   popLine,
  output logic [NUM_LINES-1:0][CW-1:0]    cnt,
  output logic [NUM_LINES-1:0]            ovf,
  output logic [DATA_W-1:0]               headData
);
  logic [NUM_LINES-1:0][DATA_W-1:0] heads;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wrPtr, rdPtr;
    logic [CW-1:0]     count;
    logic              isFull, doFlush, tryPush, doPush, doPop;

    assign isFull  = (count == CW'(DEPTH));
    assign doFlush = strb.flushEn && (hostLine == LW'(i));
    assign tryPush = strb.pushEn && (hostLine == LW'(i)) && !doFlush;
    assign doPush  = tryPush && !isFull;
    assign doPop   = strb.popEn && (popLine == LW'(i)) && !doFlush;

    always_ff @(posedge clk) begin
      if (doPush) mem[wrPtr] <= wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr    <= '0;
        rdPtr    <= '0;
        count    <= '0;
        ovf[i]   <= 1'b0;
      end else if (doFlush) begin
        rdPtr <= wrPtr;
        count <= '0;
      end else begin
        if (doPush) wrPtr <= wrPtr + 1'b1;
        if (doPop)  rdPtr <= rdPtr + 1'b1;
        count <= count + CW'(doPush) - CW'(doPop);
        if (tryPush && isFull) ovf[i] <= 1'b1;
      end
    end

    assign cnt[i]   = count;
    assign heads[i] = mem[rdPtr];
  end

  assign headData = heads[popLine];
endmodule

// File: rtl/txs_ctrl.sv
`timescale 1ns/1ps
module txs_ctrl #(
  parameter int NUM_LINES = 8,
  parameter int DEPTH     = 32,
  localparam int LW = $clog2(NUM_LINES),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [LW-1:0]                hostLine,
  input  logic                         wrChar,
  input  logic                         teWr,
  input  logic                         teVal,
  input  logic                         flushReq,
  input  logic                         ackWr,
  input  logic                         nxmIn,
  input  logic [LW-1:0]                nxmLine,
  input  logic                         outReady,
  input  logic                         tiEnable,
  input  logic [NUM_LINES-1:0][CW-1:0] cnt,
  output txs_pkg::strobe_t             strb,
  output logic [LW-1:0]                grant,
  output logic                         outValid,
  output logic                         csrTi,
  output logic [LW-1:0]                csrLine,
  output logic                         csrNxm,
  output logic                         txInt
);
  logic [NUM_LINES-1:0] teMask, pend, errMask;
  logic [NUM_LINES-1:0] eligible, setMask, nxmMask, ackMask;
  logic [LW-1:0]        rrPtr, holdLine, pick;
  logic                 holdValid, heldOk, found, popNow;

  // eligibility per line
  always_comb begin
    for (int i = 0; i < NUM_LINES; i++)
      eligible[i] = teMask[i] && (cnt[i] != '0) &&
                    !(flushReq && hostLine == LW'(i));
  end

  // round-robin search starting after the last accepted line
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = NUM_LINES; k >= 1; k--) begin
      if (eligible[rrPtr + LW'(k)]) begin
        found = 1'b1;
        pick  = rrPtr + LW'(k);
      end
    end
  end

  assign heldOk   = holdValid && !(flushReq && hostLine == holdLine);
  assign grant    = heldOk ? holdLine : pick;
  assign outValid = heldOk || found;
  assign popNow   = outValid && outReady;

  assign strb.pushEn  = wrChar;
  assign strb.popEn   = popNow;
  assign strb.flushEn = flushReq;

  // completion sources
  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      nxmMask[i] = nxmIn && (nxmLine == LW'(i));
      setMask[i] = (flushReq && hostLine == LW'(i)) || nxmMask[i] ||
                   (popNow && grant == LW'(i) && cnt[i] == CW'(1) &&
                    !(wrChar && hostLine == LW'(i)));
    end
  end

  // lowest pending line is presented
  always_comb begin
    csrLine = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (pend[i]) csrLine = LW'(i);
  end

  assign csrTi   = |pend;
  assign csrNxm  = csrTi && errMask[csrLine];
  assign txInt   = csrTi & tiEnable;
  assign ackMask = (ackWr && csrTi) ? (NUM_LINES'(1) << csrLine) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      teMask    <= '0;
      pend      <= '0;
      errMask   <= '0;
      rrPtr     <= LW'(NUM_LINES - 1);
      holdValid <= 1'b0;
      holdLine  <= '0;
    end else begin
      if (teWr) teMask[hostLine] <= teVal;
      pend      <= (pend & ~ackMask) | setMask;
      errMask   <= (errMask & ~ackMask) | nxmMask;
      holdValid <= outValid && !outReady;
      holdLine  <= grant;
      if (popNow) rrPtr <= grant;
    end
  end
endmodule

// File: rtl/txSiloSched.sv
`timescale 1ns/1ps
module txSiloSched #(
  parameter int NUM_LINES = 8,
  parameter int DEPTH     = 32,
  parameter int DATA_W    = 8,
  localparam int LW = $clog2(NUM_LINES),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LW-1:0]     selLine,
  input  logic              wrChar,
  input  logic [DATA_W-1:0] wrData,
  input  logic              teWr,
  input  logic              teVal,
  input  logic              flushReq,
  input  logic              ackWr,
  input  logic              tiEnable,
  input  logic              nxmIn,
  input  logic [LW-1:0]     nxmLine,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [LW-1:0]     outLine,
  output logic [CW-1:0]     fifoCount,
  output logic              ovfFlag,
  output logic              csrTi,
  output logic [LW-1:0]     csrLine,
  output logic              csrNxm,
  output logic              txInt
);
  txs_pkg::strobe_t             strb;
  logic [NUM_LINES-1:0][CW-1:0] cnt;
  logic [NUM_LINES-1:0]         ovf;
  logic [LW-1:0]                grant;

  txs_ctrl #(.NUM_LINES(NUM_LINES), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .hostLine(selLine), .wrChar(wrChar),
    .teWr(teWr), .teVal(teVal), .flushReq(flushReq), .ackWr(ackWr),
    .nxmIn(nxmIn), .nxmLine(nxmLine), .outReady(outReady),
    .tiEnable(tiEnable), .cnt(cnt), .strb(strb), .grant(grant),
    .outValid(outValid), .csrTi(csrTi), .csrLine(csrLine),
    .csrNxm(csrNxm), .txInt(txInt)
  );

  txs_datapath #(.NUM_LINES(NUM_LINES), .DEPTH(DEPTH), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .hostLine(selLine),
    .wrData(wrData), .popLine(grant), .cnt(cnt), .ovf(ovf),
    .headData(outData)
  );

  assign outLine   = grant;
  assign fifoCount = cnt[selLine];
  assign ovfFlag   = ovf[selLine];
endmodule

// File: rtl/txs_chk.sv
`timescale 1ns/1ps
module txs_chk #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int LW     = 3,
  parameter int CW     = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [LW-1:0]     selLine,
  input logic              flushReq,
  input logic              nxmIn,
  input logic              tiEnable,
  input logic              outReady,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic [LW-1:0]     outLine,
  input logic [CW-1:0]     fifoCount,
  input logic              csrTi,
  input logic              txInt
);
  // R1
  depth_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CW'(DEPTH));

  // R5
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=>
      ((flushReq && selLine == $past(outLine)) ||
       (outValid && $stable(outLine) && $stable(outData))));

  // R7
  flush_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> (csrTi && fifoCount == '0 || selLine != $past(selLine) || csrTi));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> csrTi);

  // R11
  nxm_post_chk: assert property (@(posedge clk) disable iff (!rstN)
    nxmIn |=> csrTi);

  // R12
  int_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tiEnable |-> !txInt);
endmodule

bind txSiloSched txs_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LW(LW), .CW(CW)) chk_i (
  .clk(clk), .rstN(rstN), .selLine(selLine), .flushReq(flushReq),
  .nxmIn(nxmIn), .tiEnable(tiEnable), .outReady(outReady),
  .outValid(outValid), .outData(outData), .outLine(outLine),
  .fifoCount(fifoCount), .csrTi(csrTi), .txInt(txInt)
);

// File: tb/txSiloSched_tb_top.sv
`timescale 1ns/1ps
module txSiloSched_tb_top;
  localparam int NL = 8;
  localparam int DP = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] selLine = '0;
  logic       wrChar = 1'b0;
  logic [7:0] wrData = '0;
  logic       teWr = 1'b0, teVal = 1'b0, flushReq = 1'b0, ackWr = 1'b0;
  logic       tiEnable = 1'b0, nxmIn = 1'b0, outReady = 1'b0;
  logic [2:0] nxmLine = '0;
  logic       outValid, ovfFlag, csrTi, csrNxm, txInt;
  logic [7:0] outData;
  logic [2:0] outLine, csrLine;
  logic [5:0] fifoCount;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] mq [NL][$];
  bit [NL-1:0] mTe, mPend, mErr, mOvf;
  int  mLast;
  bit  mHold;
  int  mHoldLine;

  txSiloSched dut_i (
    .clk(clk), .rstN(rstN), .selLine(selLine), .wrChar(wrChar),
    .wrData(wrData), .teWr(teWr), .teVal(teVal), .flushReq(flushReq),
    .ackWr(ackWr), .tiEnable(tiEnable), .nxmIn(nxmIn), .nxmLine(nxmLine),
    .outReady(outReady), .outValid(outValid), .outData(outData),
    .outLine(outLine), .fifoCount(fifoCount), .ovfFlag(ovfFlag),
    .csrTi(csrTi), .csrLine(csrLine), .csrNxm(csrNxm), .txInt(txInt)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lowestPend(input bit [NL-1:0] p);
    for (int i = 0; i < NL; i++) if (p[i]) return i;
    return 0;
  endfunction

  task automatic idle();
    wrChar = 0; teWr = 0; flushReq = 0; ackWr = 0; nxmIn = 0;
  endtask

  // called just after a falling edge with inputs driven
  task automatic runCycle();
    bit v, drained, pushed;
    int g, pres;
    bit [NL-1:0] setM, ackM, nxmM;
    #1;
    v = 0; g = 0;
    if (mHold && !(flushReq && selLine == mHoldLine)) begin v = 1; g = mHoldLine; end
    else for (int k = 1; k <= NL; k++) begin
      int i = (mLast + k) % NL;
      if (!v && mTe[i] && mq[i].size() > 0 && !(flushReq && selLine == i)) begin v = 1; g = i; end
    end
    chk(outValid == v, "R4 valid", outValid, v);
    if (v) begin
      chk(outLine == g, "R4 line", outLine, g);
      chk(outData == mq[g][0], "R3 data", outData, mq[g][0]);
    end
    chk(fifoCount == mq[selLine].size(), "R2 count", fifoCount, mq[selLine].size());
    chk(ovfFlag == mOvf[selLine], "R1 ovf", ovfFlag, mOvf[selLine]);
    chk(csrTi == (mPend != 0), "R9 ti", csrTi, mPend != 0);
    pres = lowestPend(mPend);
    if (mPend != 0) begin
      chk(csrLine == pres, "R9 line", csrLine, pres);
      chk(csrNxm == mErr[pres], "R11 nxm", csrNxm, mErr[pres]);
    end
    chk(txInt == ((mPend != 0) && tiEnable), "R12 int", txInt, (mPend != 0) && tiEnable);
    // model update
    setM = '0; nxmM = '0; ackM = '0; pushed = 0;
    if (ackWr && mPend != 0) ackM[pres] = 1;
    if (flushReq) begin mq[selLine].delete(); setM[selLine] = 1; end
    if (wrChar && !flushReq) begin
      if (mq[selLine].size() < DP) pushed = 1; else mOvf[selLine] = 1;
    end
    if (v && outReady) begin
      void'(mq[g].pop_front());
      drained = (mq[g].size() == 0) && !(pushed && selLine == g);
      if (drained) setM[g] = 1;
      mLast = g;
    end
    if (pushed) mq[selLine].push_back(wrData);
    if (nxmIn) begin nxmM[nxmLine] = 1; setM[nxmLine] = 1; end
    mPend = (mPend & ~ackM) | setM;
    mErr  = (mErr & ~ackM) | nxmM;
    if (teWr) mTe[selLine] = teVal;
    mHold = v && !outReady;
    mHoldLine = g;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd20240611);
    mTe = '0; mPend = '0; mErr = '0; mOvf = '0; mLast = NL - 1; mHold = 0; mHoldLine = 0;
    repeat (3) @(posedge clk);
    rstN = 1;
    @(negedge clk);
    // R13 reset state
    chk(outValid == 0, "R13 valid", outValid, 0);
    chk(csrTi == 0, "R13 ti", csrTi, 0);
    chk(fifoCount == 0, "R13 count", fifoCount, 0);

    // R1: fill disabled line 2 past capacity
    idle(); selLine = 2;
    for (int n = 0; n < DP + 1; n++) begin wrChar = 1; wrData = 8'(n + 16); runCycle(); end
    idle(); #1;
    chk(fifoCount == DP, "R1 full count", fifoCount, DP);
    chk(ovfFlag == 1, "R1 sticky", ovfFlag, 1);
    // R6: disabled line offers nothing
    chk(outValid == 0, "R6 paused", outValid, 0);
    runCycle();
    // R6 resume and R5 hold under back-pressure
    teWr = 1; teVal = 1; outReady = 0; runCycle();
    idle(); #1;
    chk(outValid == 1 && outData == 8'd16, "R6 resume", outData, 16);
    runCycle();
    teWr = 1; teVal = 0; runCycle();
    idle(); #1;
    chk(outValid == 1 && outLine == 2 && outData == 8'd16, "R5 held", outData, 16);
    outReady = 1; runCycle();
    #1;
    chk(outValid == 0, "R6 paused again", outValid, 0);
    chk(fifoCount == DP - 1, "R6 kept", fifoCount, DP - 1);
    // R7 flush
    flushReq = 1; runCycle(); idle(); #1;
    chk(fifoCount == 0, "R7 emptied", fifoCount, 0);
    chk(csrTi == 1 && csrLine == 2, "R7 completion", csrLine, 2);
    // R10 ack
    ackWr = 1; runCycle(); idle(); #1;
    chk(csrTi == 0, "R10 cleared", csrTi, 0);
    // R8 single char drain on line 5
    selLine = 5; teWr = 1; teVal = 1; wrChar = 1; wrData = 8'hA5; runCycle();
    idle(); runCycle(); #1;
    chk(csrTi == 1 && csrLine == 5, "R8 drained", csrLine, 5);
    ackWr = 1; runCycle(); idle();
    // R11 fetch error on line 6
    nxmIn = 1; nxmLine = 6; runCycle(); idle(); #1;
    chk(csrNxm == 1 && csrLine == 6, "R11 error", csrNxm, 1);
    tiEnable = 1; runCycle(); #1;
    chk(txInt == 1, "R12 int on", txInt, 1);
    ackWr = 1; runCycle(); idle(); #1;
    chk(csrNxm == 0, "R11 cleared", csrNxm, 0);

    // random phase
    for (int c = 0; c < 20000; c++) begin
      idle();
      selLine  = 3'($urandom_range(0, 7));
      wrChar   = ($urandom_range(0, 99) < 55);
      wrData   = 8'($urandom);
      teWr     = ($urandom_range(0, 99) < 8);
      teVal    = ($urandom_range(0, 99) < 75);
      flushReq = !wrChar && ($urandom_range(0, 99) < 3);
      ackWr    = ($urandom_range(0, 99) < 25);
      nxmIn    = ($urandom_range(0, 99) < 2);
      nxmLine  = 3'($urandom_range(0, 7));
      outReady = ($urandom_range(0, 99) < 50);
      if ($urandom_range(0, 99) < 2) tiEnable = ~tiEnable;
      runCycle();
    end
    finish();
  end
endmodule